// File: doc/BRIEF.md
# Four-Channel DMA Transfer Controller

This block moves single bytes between an I/O device and memory on behalf of four requesting devices. The CPU sets it up through a small register window. Each channel has a 16-bit memory address and a count word, which holds a 14-bit count and a 2-bit transfer type. A mode register holds the per-channel enables and the arbitration policy. A status register holds the terminal-count flags. A 4-bit register select and 8-bit data ports give access to all of these.

When an enabled channel raises its request, the controller asserts a hold request to the CPU. It waits for hold acknowledge, then takes the bus. Every byte moves through four states: address, strobe assert, strobe hold and release. During these states the controller drives the following outputs:
- the low address nibble on the address lines;
- the next nibble on a second output;
- the upper address byte on the data output, for an external latch that captures it on the address strobe;
- the read and write strobes that match the transfer type.

The channel's acknowledge stays high for the whole byte. A terminal-count pulse marks a channel's final byte. A mark pulse appears on every 128th byte of a channel's run.

The sequencer has six states:
- `ST_IDLE` (bus released). It moves to `ST_HREQ` when an enabled request is pending.
- `ST_HREQ` (hold requested). It moves to `ST_ADDR` when hold acknowledge is high and a request is still pending. It returns to `ST_IDLE` when the request goes away.
- `ST_ADDR` moves to `ST_STRB`, then to `ST_SHLD`, then to `ST_REL`.
- `ST_REL` moves straight back to `ST_ADDR` if another enabled request is pending and acknowledge is still high. It moves to `ST_HREQ` if a request is pending but acknowledge has dropped. Otherwise it moves to `ST_IDLE`.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset the following outputs are low: hold request, all acknowledges, all four strobes, address strobe, terminal count and mark. All channel enables are clear and the status register reads 0.
- R2: Register select 2c+0 is the address of channel c and 2c+1 is its count word. Each 16-bit register is written or read as two bytes, low byte first. A single first/last flip-flop is shared by all channels and toggles on every channel access. A write to register select 8 (mode) resets the flip-flop to the low byte.
- R3: A pending request on an enabled channel raises hold request in the next cycle. No acknowledge, address strobe or read/write strobe is driven before hold acknowledge has been seen high.
- R4: In fixed mode (mode bit 4 = 0), the lowest-numbered pending channel wins, so channel 0 has the highest priority.
- R5: In rotating mode (mode bit 4 = 1), the channel just granted becomes the lowest priority. Two channels that keep requesting are therefore served alternately.
- R6: Each byte takes four cycles. The address strobe is high only in the first cycle. The read/write strobes are high in the second and third cycles. The one-hot acknowledge of the served channel is high in all four cycles.
- R7: Count word bits 15:14 give the transfer type. 01 is a write: I/O read together with memory write. 10 is a read: memory read together with I/O write. 00 and 11 are verify: no strobes.
- R8: During a byte, the three address outputs carry the channel address: the low address nibble output carries bits 3:0, the second address output carries bits 7:4, and the data output carries bits 15:8. The address is incremented by one after each byte and wraps at 16 bits.
- R9: A programmed count C gives C+1 bytes. Terminal count is high in the release cycle of the last byte, and that channel's enable bit is then cleared.
- R10: Mark is high in the release cycle of each 128th byte counted from the last write of the channel's count word.
- R11: A read of register select 8 returns the terminal-count flags in bits 3:0, and the read clears them.
- R12: When another enabled request is pending at release, the next byte starts in the following cycle, so bytes run 4 cycles apart. Otherwise hold request drops in the following cycle.
- R13: A request on a channel whose enable bit is clear has no effect, and hold request stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low register window select |
| cpu_rd | input | 1 | One-cycle register read pulse |
| cpu_wr | input | 1 | One-cycle register write pulse |
| reg_sel | input | 4 | Register select, used only while the bus is released |
| data_in | input | 8 | Register write data |
| data_out | output | 8 | Register read data; upper address byte while transferring |
| addr_lo | output | 4 | Address bits 3:0 while transferring |
| addr_hi | output | 4 | Address bits 7:4 while transferring |
| addr_stb | output | 1 | Strobe that loads data_out into the external latch |
| dreq | input | 4 | Channel requests |
| dack | output | 4 | One-hot channel acknowledge |
| hold_req | output | 1 | Bus hold request to the CPU |
| hold_ack | input | 1 | Bus hold acknowledge from the CPU |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| tc | output | 1 | Terminal count, release cycle of last byte |
| mark | output | 1 | Release cycle of every 128th byte |

## Verification
A table of runs on a single channel covers each of the three transfer types, so wrong strobe pairs or strobes leaking on verify runs are told apart. The same runs use addresses that carry across a byte boundary and across the 16-bit wrap, which separates a bad increment or a misplaced address byte. Two channels requesting together under fixed and then rotating arbitration show back-to-back runs against strict alternation. A delayed hold acknowledge, a disabled requester, a 200-byte run for the mark and an interrupted byte pair before a mode write each isolate one corner of the handshake, counting and register access.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HREQ,
        ST_ADDR,
        ST_STRB,
        ST_SHLD,
        ST_REL
    } dma_state_t;

    typedef enum logic [1:0] {
        XF_VERIFY = 2'b00,
        XF_WRITE  = 2'b01,
        XF_READ   = 2'b10,
        XF_BAD    = 2'b11
    } xfer_t;

    localparam logic [3:0] SEL_MODE = 4'h8;

endpackage

// File: rtl/dma4_regs.sv
module dma4_regs
    import dma4_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int AW          = 16,
    parameter int CW          = 14,
    parameter int MARK_PERIOD = 128
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_stb,
    input  logic                       rd_stb,
    input  logic [3:0]                 sel,
    input  logic [7:0]                 wdata,
    input  logic                       done,
    input  logic [$clog2(NCH)-1:0]     cur_ch,
    output logic [7:0]                 rdata,
    output logic [NCH-1:0]             en,
    output logic                       rotate,
    output logic [AW-1:0]              cur_addr,
    output xfer_t                      cur_type,
    output logic                       cur_last,
    output logic                       cur_mark
);
    localparam int CH_W  = $clog2(NCH);
    localparam int MW    = $clog2(MARK_PERIOD);
    localparam int CHI_W = CW - 8;

    logic [AW-1:0] addr_v [NCH];
    logic [CW-1:0] cnt_v  [NCH];
    logic [1:0]    typ_v  [NCH];
    logic [MW-1:0] blk_v  [NCH];

    logic            ff_q;
    logic            rot_q;
    logic [NCH-1:0]  en_q;
    logic [NCH-1:0]  tcf_q;

    logic            is_chan;
    logic            is_mode;
    logic [CH_W-1:0] ch_sel;
    logic            finish;

    assign is_chan = !sel[3];
    assign is_mode = (sel == SEL_MODE);
    assign ch_sel  = sel[CH_W:1];
    assign finish  = done && cur_last;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [AW-1:0] a_q;
        logic [CW-1:0] c_q;
        logic [1:0]    t_q;
        logic [MW-1:0] b_q;
        logic          hit;

        assign hit = wr_stb && is_chan && (ch_sel == CH_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_q <= '0;
                c_q <= '0;
                t_q <= 2'b00;
                b_q <= '0;
            end else if (hit) begin
                if (!sel[0]) begin
                    if (!ff_q) a_q[7:0]    <= wdata;
                    else       a_q[AW-1:8] <= wdata[AW-9:0];
                end else begin
                    if (!ff_q) begin
                        c_q[7:0] <= wdata;
                    end else begin
                        c_q[CW-1:8] <= wdata[CHI_W-1:0];
                        t_q         <= wdata[7:6];
                        b_q         <= '0;
                    end
                end
            end else if (done && cur_ch == CH_W'(g)) begin
                a_q <= a_q + AW'(1);
                if (c_q != '0) c_q <= c_q - CW'(1);
                b_q <= (b_q == MW'(MARK_PERIOD - 1)) ? '0 : b_q + MW'(1);
            end
        end

        assign addr_v[g] = a_q;
        assign cnt_v[g]  = c_q;
        assign typ_v[g]  = t_q;
        assign blk_v[g]  = b_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ff_q  <= 1'b0;
            rot_q <= 1'b0;
            en_q  <= '0;
            tcf_q <= '0;
        end else begin
            if (wr_stb && is_mode)
                ff_q <= 1'b0;
            else if ((wr_stb || rd_stb) && is_chan)
                ff_q <= !ff_q;

            if (wr_stb && is_mode) begin
                en_q  <= wdata[NCH-1:0];
                rot_q <= wdata[4];
            end else if (finish) begin
                en_q[cur_ch] <= 1'b0;
            end

            if (rd_stb && is_mode)
                tcf_q <= '0;
            else if (finish)
                tcf_q[cur_ch] <= 1'b1;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (is_mode) begin
            rdata[NCH-1:0] = tcf_q;
        end else if (is_chan) begin
            if (!sel[0])
                rdata = ff_q ? addr_v[ch_sel][15:8] : addr_v[ch_sel][7:0];
            else
                rdata = ff_q ? {typ_v[ch_sel], cnt_v[ch_sel][CW-1:8]} : cnt_v[ch_sel][7:0];
        end
    end

    assign en       = en_q;
    assign rotate   = rot_q;
    assign cur_addr = addr_v[cur_ch];
    assign cur_type = xfer_t'(typ_v[cur_ch]);
    assign cur_last = (cnt_v[cur_ch] == '0);
    assign cur_mark = (blk_v[cur_ch] == MW'(MARK_PERIOD - 1));

    // R9: the finishing channel loses its enable
    assert_tc_clears_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cur_last) |=> !en_q[$past(cur_ch)]);

    // R8: the served channel's address steps by one
    assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wr_stb) |=> (addr_v[$past(cur_ch)] == $past(cur_addr) + AW'(1)));

    // R11: reading status empties it
    assert_status_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && is_mode && !done) |=> (tcf_q == '0));

    // R2: a mode write leaves the byte pointer at the low byte
    assert_mode_resets_ff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && is_mode) |=> !ff_q);
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
    parameter int NCH = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         req,
    input  logic                   rotate,
    input  logic                   take,
    output logic                   gnt_valid,
    output logic [$clog2(NCH)-1:0] gnt_idx
);
    localparam int CH_W = $clog2(NCH);

    logic [CH_W-1:0] last_q;

    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = 0; k < NCH; k++) begin
            logic [CH_W-1:0] cand;
            cand = rotate ? CH_W'((int'(last_q) + 1 + k) % NCH) : CH_W'(k);
            if (!gnt_valid && req[cand]) begin
                gnt_valid = 1'b1;
                gnt_idx   = cand;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= CH_W'(NCH - 1);
        else if (take && gnt_valid)
            last_q <= gnt_idx;
    end

    // R4: a grant always goes to a requester, and channel 0 wins in fixed mode
    assert_gnt_requested_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> req[gnt_idx]);
    assert_fixed_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rotate && req[0]) |-> (gnt_valid && gnt_idx == '0));

    // R5: in rotating mode the previous winner is not picked again while another waits
    assert_rotate_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rotate && take && gnt_valid && ($countones(req) > 1)) |-> (gnt_idx != last_q));
endmodule

// File: rtl/dma4_fsm.sv
module dma4_fsm
    import dma4_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   any_req,
    input  logic                   hold_ack,
    input  logic [$clog2(NCH)-1:0] gnt_idx,
    input  xfer_t                  cur_type,
    input  logic                   cur_last,
    input  logic                   cur_mark,
    output logic [$clog2(NCH)-1:0] cur_ch,
    output logic                   take,
    output logic                   done,
    output logic                   master,
    output logic                   hold_req,
    output logic                   addr_stb,
    output logic                   mem_rd,
    output logic                   mem_wr,
    output logic                   io_rd,
    output logic                   io_wr,
    output logic [NCH-1:0]         dack,
    output logic                   tc,
    output logic                   mark
);
    dma_state_t st_q, st_d;

    assign take = any_req && hold_ack && (st_q == ST_HREQ || st_q == ST_REL);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (any_req) st_d = ST_HREQ;
            ST_HREQ: begin
                if (!any_req)      st_d = ST_IDLE;
                else if (hold_ack) st_d = ST_ADDR;
            end
            ST_ADDR: st_d = ST_STRB;
            ST_STRB: st_d = ST_SHLD;
            ST_SHLD: st_d = ST_REL;
            ST_REL: begin
                if (!any_req)      st_d = ST_IDLE;
                else if (hold_ack) st_d = ST_ADDR;
                else               st_d = ST_HREQ;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    cur_ch <= '0;
        else if (take) cur_ch <= gnt_idx;
    end

    always_comb begin
        logic strobe;
        hold_req = 1'b0;
        master   = 1'b0;
        addr_stb = 1'b0;
        done     = 1'b0;
        strobe   = 1'b0;
        tc       = 1'b0;
        mark     = 1'b0;
        dack     = '0;
        unique case (st_q)
            ST_IDLE: ;
            ST_HREQ: hold_req = 1'b1;
            ST_ADDR: begin
                hold_req     = 1'b1;
                master       = 1'b1;
                addr_stb     = 1'b1;
                dack[cur_ch] = 1'b1;
            end
            ST_STRB, ST_SHLD: begin
                hold_req     = 1'b1;
                master       = 1'b1;
                strobe       = 1'b1;
                dack[cur_ch] = 1'b1;
            end
            ST_REL: begin
                hold_req     = 1'b1;
                master       = 1'b1;
                done         = 1'b1;
                tc           = cur_last;
                mark         = cur_mark;
                dack[cur_ch] = 1'b1;
            end
            default: ;
        endcase
        io_rd  = strobe && (cur_type == XF_WRITE);
        mem_wr = strobe && (cur_type == XF_WRITE);
        mem_rd = strobe && (cur_type == XF_READ);
        io_wr  = strobe && (cur_type == XF_READ);
    end

    // R3: bus cycles start only after acknowledge was seen
    assert_ack_before_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ADDR) |-> $past(hold_ack));
    assert_quiet_without_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_req |-> (dack == '0 && !addr_stb && !mem_rd && !mem_wr && !io_rd && !io_wr));

    // R6: one acknowledge, address strobe a single cycle followed by two strobe cycles
    assert_dack_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));
    assert_stb_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb |=> (!addr_stb && $stable(dack)));

    // R7: never both directions on the same space
    assert_no_clash_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr) && !(io_rd && io_wr));

    // R12: nothing pending at release means the hold is given back
    assert_hold_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !any_req) |=> !hold_req);
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
    import dma4_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int AW          = 16,
    parameter int CW          = 14,
    parameter int MARK_PERIOD = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       cpu_rd,
    input  logic       cpu_wr,
    input  logic [3:0] reg_sel,
    input  logic [7:0] data_in,
    output logic [7:0] data_out,
    output logic [3:0] addr_lo,
    output logic [3:0] addr_hi,
    output logic       addr_stb,
    input  logic [3:0] dreq,
    output logic [3:0] dack,
    output logic       hold_req,
    input  logic       hold_ack,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       io_rd,
    output logic       io_wr,
    output logic       tc,
    output logic       mark
);
    localparam int CH_W = $clog2(NCH);

    logic [CH_W-1:0] cur_ch;
    logic [CH_W-1:0] gnt_idx;
    logic            gnt_valid;
    logic            take;
    logic            done;
    logic            master;
    logic            wr_stb;
    logic            rd_stb;
    logic [7:0]      rdata;
    logic [NCH-1:0]  en;
    logic            rotate;
    logic [AW-1:0]   cur_addr;
    xfer_t           cur_type;
    logic            cur_last;
    logic            cur_mark;
    logic [NCH-1:0]  live_req;
    logic [NCH-1:0]  drop_mask;

    assign wr_stb = !cs_n && cpu_wr && !master;
    assign rd_stb = !cs_n && cpu_rd && !master;

    always_comb begin
        drop_mask = '0;
        if (done && cur_last) drop_mask[cur_ch] = 1'b1;
    end
    assign live_req = dreq & en & ~drop_mask;

    dma4_regs #(
        .NCH(NCH), .AW(AW), .CW(CW), .MARK_PERIOD(MARK_PERIOD)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(wr_stb), .rd_stb(rd_stb),
        .sel(reg_sel), .wdata(data_in),
        .done(done), .cur_ch(cur_ch),
        .rdata(rdata), .en(en), .rotate(rotate),
        .cur_addr(cur_addr), .cur_type(cur_type),
        .cur_last(cur_last), .cur_mark(cur_mark)
    );

    dma4_arb #(.NCH(NCH)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .req(live_req), .rotate(rotate), .take(take),
        .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
    );

    dma4_fsm #(.NCH(NCH)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .any_req(gnt_valid), .hold_ack(hold_ack),
        .gnt_idx(gnt_idx), .cur_type(cur_type),
        .cur_last(cur_last), .cur_mark(cur_mark),
        .cur_ch(cur_ch), .take(take), .done(done), .master(master),
        .hold_req(hold_req), .addr_stb(addr_stb),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
        .dack(dack), .tc(tc), .mark(mark)
    );

    assign data_out = master ? cur_addr[15:8] : rdata;
    assign addr_lo  = master ? cur_addr[3:0]  : 4'h0;
    assign addr_hi  = master ? cur_addr[7:4]  : 4'h0;

    // R13: a disabled channel never gets an acknowledge
    assert_disabled_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (dack != '0) |-> ((dack & en) != '0 || tc));
endmodule

// File: tb/sim_dma4_ctrl.sv
module sim_dma4_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [3:0] reg_sel = 4'h0;
    logic [7:0] data_in = 8'h00;
    logic [7:0] data_out;
    logic [3:0] addr_lo, addr_hi, dreq = 4'h0, dack;
    logic       addr_stb, hold_req, hold_ack = 1'b0;
    logic       mem_rd, mem_wr, io_rd, io_wr, tc, mark;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit ack_auto = 1'b1;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dma4_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .reg_sel(reg_sel), .data_in(data_in), .data_out(data_out),
        .addr_lo(addr_lo), .addr_hi(addr_hi), .addr_stb(addr_stb),
        .dreq(dreq), .dack(dack), .hold_req(hold_req), .hold_ack(hold_ack),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
        .tc(tc), .mark(mark)
    );

    initial forever begin
        @(negedge clk);
        hold_ack <= hold_req && ack_auto;
    end

    // per-byte log, filled at negedges
    int        log_n = 0;
    int        ph = 0;
    logic [3:0]  log_dack [1024];
    logic [15:0] log_addr [1024];
    logic [3:0]  log_strb [1024];
    logic        log_tc   [1024];
    logic        log_mark [1024];
    int          log_t    [1024];

    always @(negedge clk) if (rst_n) begin
        if (addr_stb) begin
            log_dack[log_n] = dack;
            log_addr[log_n] = {data_out, addr_hi, addr_lo};
            log_t[log_n]    = cyc;
            ph = 1;
        end else if (ph == 1) begin
            log_strb[log_n] = {mem_rd, mem_wr, io_rd, io_wr};
            ph = 2;
        end else if (ph == 2) begin
            ph = 3;
        end else if (ph == 3) begin
            log_tc[log_n]   = tc;
            log_mark[log_n] = mark;
            log_n = log_n + 1;
            ph = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; cpu_wr = 1'b1; reg_sel = s; data_in = d;
        @(negedge clk);
        cs_n = 1'b1; cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] s, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; cpu_rd = 1'b1; reg_sel = s;
        #1 d = data_out;
        @(negedge clk);
        cs_n = 1'b1; cpu_rd = 1'b0;
    endtask

    task automatic prog(input int ch, input logic [15:0] a, input logic [1:0] t, input logic [13:0] c);
        wr(4'h8, 8'h00);
        wr(4'(ch * 2), a[7:0]);
        wr(4'(ch * 2), a[15:8]);
        wr(4'(ch * 2 + 1), c[7:0]);
        wr(4'(ch * 2 + 1), {t, c[13:8]});
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (!hold_req && n < 50) begin @(negedge clk); n++; end
        n = 0;
        while (hold_req && n < 5000) begin @(negedge clk); n++; end
        chk(n < 5000, req, n, 0);
    endtask

    function automatic logic [3:0] exp_strb(input logic [1:0] t);
        if (t == 2'b01) return 4'b0110;
        if (t == 2'b10) return 4'b1001;
        return 4'b0000;
    endfunction

    // {channel, type, address, count}
    localparam logic [33:0] VEC [5] = '{
        {2'd0, 2'b01, 16'h12F0, 14'd2},
        {2'd1, 2'b10, 16'h00FF, 14'd1},
        {2'd2, 2'b00, 16'hABCD, 14'd0},
        {2'd3, 2'b01, 16'hFFFF, 14'd1},
        {2'd2, 2'b11, 16'h4000, 14'd3}
    };

    initial begin
        #(4 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] b0, b1;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk({hold_req, dack, addr_stb, mem_rd, mem_wr, io_rd, io_wr, tc, mark} == 0,
            "R1 outputs", {hold_req, dack, mem_rd, mem_wr, io_rd, io_wr, tc, mark}, 0);
        rd(4'h8, b0);
        chk(b0 == 0, "R1 status", b0, 0);

        // R2: byte order and first/last flip-flop
        wr(4'h2, 8'hEF); wr(4'h2, 8'hBE);
        rd(4'h2, b0); rd(4'h2, b1);
        chk({b1, b0} == 16'hBEEF, "R2 address readback", {b1, b0}, 16'hBEEF);
        wr(4'h3, 8'h34);
        wr(4'h8, 8'h00);
        wr(4'h3, 8'h12); wr(4'h3, 8'h80);
        rd(4'h3, b0); rd(4'h3, b1);
        chk({b1, b0} == 16'h8012, "R2 mode write resets pointer", {b1, b0}, 16'h8012);

        // table of single-channel runs: R6 R7 R8 R9 R11 R12 R13
        for (int i = 0; i < 5; i++) begin
            int ch;
            logic [1:0]  t;
            logic [15:0] a;
            logic [13:0] c;
            int bad_d, bad_a, bad_s, bad_t, bad_g;
            {ch, t, a, c} = {30'd0, VEC[i]};
            ch = int'(VEC[i][33:32]);
            prog(ch, a, t, c);
            base = log_n;
            wr(4'h8, 8'(1 << ch));
            dreq = 4'(1 << ch);
            wait_idle("R12 run ends");
            chk(log_n - base == int'(c) + 1, "R9 byte count", log_n - base, int'(c) + 1);
            bad_d = 0; bad_a = 0; bad_s = 0; bad_t = 0; bad_g = 0;
            for (int k = 0; k < log_n - base; k++) begin
                if (log_dack[base + k] != 4'(1 << ch)) bad_d++;
                if (log_addr[base + k] != a + 16'(k)) bad_a++;
                if (log_strb[base + k] != exp_strb(t)) bad_s++;
                if (log_tc[base + k] != (k == int'(c))) bad_t++;
                if (k > 0 && log_t[base + k] - log_t[base + k - 1] != 4) bad_g++;
            end
            chk(bad_d == 0, "R6 acknowledge", bad_d, 0);
            chk(bad_a == 0, "R8 address sequence", bad_a, 0);
            chk(bad_s == 0, "R7 strobes for type", bad_s, 0);
            chk(bad_t == 0, "R9 terminal count", bad_t, 0);
            chk(bad_g == 0, "R12 back-to-back spacing", bad_g, 0);
            rd(4'h8, b0);
            chk(b0 == 8'(1 << ch), "R11 status flag", b0, 1 << ch);
            rd(4'h8, b0);
            chk(b0 == 0, "R11 status cleared", b0, 0);
            begin
                int seen = 0;
                repeat (8) begin @(negedge clk); if (hold_req) seen++; end
                chk(seen == 0, "R9 enable cleared after count", seen, 0);
            end
            dreq = 4'h0;
        end

        // R13: disabled channel
        prog(1, 16'h0100, 2'b01, 14'd0);
        wr(4'h8, 8'h00);
        dreq = 4'b0010;
        begin
            int seen = 0;
            repeat (10) begin @(negedge clk); if (hold_req) seen++; end
            chk(seen == 0, "R13 disabled request ignored", seen, 0);
        end
        dreq = 4'h0;

        // R3: delayed acknowledge
        ack_auto = 1'b0;
        prog(0, 16'h0200, 2'b10, 14'd0);
        wr(4'h8, 8'h01);
        dreq = 4'b0001;
        @(negedge clk); @(negedge clk);
        chk(hold_req == 1'b1, "R3 hold raised", hold_req, 1);
        begin
            int busy = 0;
            repeat (6) begin
                @(negedge clk);
                if (dack != 0 || addr_stb || mem_rd || mem_wr || io_rd || io_wr) busy++;
            end
            chk(busy == 0, "R3 idle until acknowledge", busy, 0);
        end
        base = log_n;
        ack_auto = 1'b1;
        wait_idle("R3 run ends");
        chk(log_n - base == 1, "R3 one byte after acknowledge", log_n - base, 1);
        dreq = 4'h0;
        rd(4'h8, b0);

        // R4: fixed priority, channels 0 and 1
        prog(0, 16'h1000, 2'b01, 14'd2);
        prog(1, 16'h2000, 2'b01, 14'd2);
        wr(4'h8, 8'h03);
        base = log_n;
        dreq = 4'b0011;
        wait_idle("R4 run ends");
        begin
            logic [3:0] exp [6] = '{4'd1, 4'd1, 4'd1, 4'd2, 4'd2, 4'd2};
            int bad = 0;
            for (int k = 0; k < 6; k++) if (log_dack[base + k] != exp[k]) bad++;
            chk(bad == 0 && log_n - base == 6, "R4 fixed order", bad, 0);
        end
        dreq = 4'h0;
        rd(4'h8, b0);

        // R4: lower channel first among 1 and 2
        prog(1, 16'h3000, 2'b00, 14'd0);
        prog(2, 16'h3100, 2'b00, 14'd0);
        wr(4'h8, 8'h06);
        base = log_n;
        dreq = 4'b0110;
        wait_idle("R4 second run ends");
        chk(log_dack[base] == 4'b0010, "R4 channel 1 before 2", log_dack[base], 2);
        dreq = 4'h0;
        rd(4'h8, b0);

        // R5: rotating priority alternates
        prog(0, 16'h1000, 2'b01, 14'd2);
        prog(1, 16'h2000, 2'b01, 14'd2);
        wr(4'h8, 8'h13);
        base = log_n;
        dreq = 4'b0011;
        wait_idle("R5 run ends");
        begin
            int bad = 0;
            for (int k = 1; k < 6; k++) if (log_dack[base + k] == log_dack[base + k - 1]) bad++;
            chk(bad == 0 && log_n - base == 6, "R5 alternation", bad, 0);
        end
        dreq = 4'h0;
        rd(4'h8, b0);

        // R10: mark on the 128th byte of a 200-byte run
        prog(0, 16'h8000, 2'b01, 14'd199);
        wr(4'h8, 8'h01);
        base = log_n;
        dreq = 4'b0001;
        wait_idle("R10 run ends");
        begin
            int marks = 0;
            for (int k = 0; k < log_n - base; k++) if (log_mark[base + k]) marks++;
            chk(marks == 1, "R10 mark count", marks, 1);
            chk(log_mark[base + 127] == 1'b1, "R10 mark on byte 128", log_mark[base + 127], 1);
            chk(log_n - base == 200, "R9 long run length", log_n - base, 200);
        end
        dreq = 4'h0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule